// File: doc/BRIEF.md
# Tiny Prefetch Line Buffer

This block is a small direct-mapped read buffer that sits between a core's memory ports and system memory. It stays in use only while the core's main cache is switched off. It keeps a few recently fetched lines so that repeated reads to the same neighbourhood skip the memory round trip. The top holds two buffers: one serves the instruction-fetch port and one serves the data port. Each buffer has its own memory channel. Memory is a request/response interface that returns a whole line per read.

A small control register holds a separate enable bit for each port and one invalidate bit that both buffers share. The buffers do not watch writes from other bus masters. A line can therefore go stale, and software is responsible for coherence. It sets the invalidate bit before it reads shared data, then clears the bit again. Writes from the data port go straight through to memory. A write also patches any valid copy of the addressed line, so the issuing core never reads back its own old data.

Top module: `pfb_top`

## Requirements
- R1: After reset every line in both buffers is invalid, both ports are ready, no response or memory request is pending, and both enables are on with invalidate off, so the first read of any address is a miss.
- R2: A read that finds a valid line with a matching tag returns the addressed word with rvalid exactly one cycle after acceptance, and issues no memory request.
- R3: A read miss issues one line-aligned memory read (low offset bits zero) and holds ready low until the memory response. rvalid follows one cycle after the response. When the buffer is in use, the line is stored; word k of a line sits at bits [k*DATA_W +: DATA_W].
- R4: The line index is address bits [OFF_W +: IDX_W] (bits 4:2 with defaults) and the tag is the bits above. A miss to a different tag at the same index replaces the old line.
- R5: While cache_on_i is 1, every read goes to memory and nothing is filled. Lines that were valid before stay valid and hit again once cache_on_i returns to 0.
- R6: Control bit 0 enables the instruction buffer and bit 1 enables the data buffer. A port whose bit is 0 sends every read to memory without filling, and the other port is unaffected.
- R7: Control bit 2 is the invalidate bit. While it is 1, all lines of both buffers are cleared, every read misses and no line is filled. After it returns to 0, filling resumes.
- R8: One invalidate clears the instruction buffer and the data buffer together.
- R9: If the invalidate bit is seen at any point while a line fetch is outstanding, that line is not stored.
- R10: A data-port write is sent to memory with its full word address and data. Ready stays low until the memory acknowledge, and rvalid pulses one cycle after it. A valid line holding that address has its word updated. A write to an uncached line allocates nothing.
- R11: A change made to memory by another master is not seen by the buffer. A held line keeps returning the old value until an invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cache_on_i | input | 1 | Main cache enabled; forces bypass |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | Control value: bit0 instr enable, bit1 data enable, bit2 invalidate |
| ireq_i | input | 1 | Instruction read request |
| iaddr_i | input | ADDR_W | Instruction word address |
| iready_o | output | 1 | Instruction port can accept a request |
| irvalid_o | output | 1 | Instruction read data valid |
| irdata_o | output | DATA_W | Instruction read data |
| imem_req_o | output | 1 | Instruction-side memory request |
| imem_addr_o | output | ADDR_W | Instruction-side memory word address |
| imem_rvalid_i | input | 1 | Instruction-side memory response |
| imem_rline_i | input | DATA_W*WORDS | Instruction-side returned line |
| dreq_i | input | 1 | Data request |
| dwe_i | input | 1 | Data request is a write |
| daddr_i | input | ADDR_W | Data word address |
| dwdata_i | input | DATA_W | Data write value |
| dready_o | output | 1 | Data port can accept a request |
| drvalid_o | output | 1 | Data response valid (read data or write done) |
| drdata_o | output | DATA_W | Data read value |
| dmem_req_o | output | 1 | Data-side memory request |
| dmem_we_o | output | 1 | Data-side memory request is a write |
| dmem_addr_o | output | ADDR_W | Data-side memory word address |
| dmem_wdata_o | output | DATA_W | Data-side memory write value |
| dmem_rvalid_i | input | 1 | Data-side memory response or write acknowledge |
| dmem_rline_i | input | DATA_W*WORDS | Data-side returned line |

## Verification
The bench goes after index aliasing. A design that decodes the index or tag from the wrong bits would hit on a conflicting address or miss on a word of a resident line. It also pulses invalidate while a fetch is still outstanding. A design without the in-flight kill would store that line and serve the next read as a one-cycle hit. Stale data from a foreign write must survive until invalidate and then be replaced. A write to a resident line must show up in the next hit, or the core would read its own old value. Bypass through cache_on_i and through each port's enable bit must neither fill lines nor lose the ones already held.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRITE} pfb_state_e;
  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned CTRL_IEN = 0;
  localparam int unsigned CTRL_DEN = 1;
  localparam int unsigned CTRL_INV = 2;
endpackage

// File: rtl/pfb_ctrl_reg.sv
module pfb_ctrl_reg
  import pfb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              ien_o,
  output logic              den_o,
  output logic              inval_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q           <= '0;
      ctrl_q[CTRL_IEN] <= 1'b1;
      ctrl_q[CTRL_DEN] <= 1'b1;
    end else if (we_i) begin
      ctrl_q <= wdata_i;
    end
  end

  assign ien_o   = ctrl_q[CTRL_IEN];
  assign den_o   = ctrl_q[CTRL_DEN];
  assign inval_o = ctrl_q[CTRL_INV];
endmodule

// File: rtl/pfb_store.sv
module pfb_store #(
  parameter  int unsigned LINES  = 8,
  parameter  int unsigned WORDS  = 4,
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned TAG_W  = 11,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned OFF_W  = $clog2(WORDS),
  localparam int unsigned LINE_W = DATA_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [OFF_W-1:0]  upd_off_i,
  input  logic [DATA_W-1:0] upd_word_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [OFF_W-1:0]  lk_off_i,
  output logic              lk_valid_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_word_o
);
  logic [LINES-1:0]  valid_w;
  logic [TAG_W-1:0]  tag_w  [LINES];
  logic [LINE_W-1:0] line_w [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic              fill_here, upd_here, valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    assign fill_here = fill_i && (fill_idx_i == IDX_W'(l));
    assign upd_here  = upd_i && (upd_idx_i == IDX_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        valid_q <= 1'b0;
      else if (clear_i)   valid_q <= 1'b0;
      else if (fill_here) valid_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (fill_here) begin
        tag_q  <= fill_tag_i;
        line_q <= fill_line_i;
      end else if (upd_here) begin
        for (int w = 0; w < WORDS; w++)
          if (upd_off_i == OFF_W'(w)) line_q[w*DATA_W +: DATA_W] <= upd_word_i;
      end
    end

    assign valid_w[l] = valid_q;
    assign tag_w[l]   = tag_q;
    assign line_w[l]  = line_q;
  end

  always_comb begin
    lk_valid_o = valid_w[lk_idx_i];
    lk_tag_o   = tag_w[lk_idx_i];
    lk_word_o  = '0;
    for (int w = 0; w < WORDS; w++)
      if (lk_off_i == OFF_W'(w)) lk_word_o = line_w[lk_idx_i][w*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/pfb_line_buf.sv
module pfb_line_buf
  import pfb_pkg::*;
#(
  parameter  int unsigned ADDR_W = 16,
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned WORDS  = 4,
  parameter  int unsigned LINES  = 8,
  parameter  bit          HAS_WR = 1'b1,
  localparam int unsigned OFF_W  = $clog2(WORDS),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned LINE_W = DATA_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              inval_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [LINE_W-1:0] mem_rline_i
);
  pfb_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, lk_addr;
  logic [DATA_W-1:0] wdata_q, rdata_q, lk_word, resp_word;
  logic              use_q, kill_q, rvalid_q;
  logic              wr_req, accept, lk_valid, tag_match, rd_hit, resp, fill, upd;
  logic [TAG_W-1:0]  st_tag;

  assign wr_req  = HAS_WR && we_i;
  assign accept  = req_i && (state_q == ST_IDLE);
  assign lk_addr = (state_q == ST_IDLE) ? addr_i : addr_q;

  pfb_store #(
    .LINES (LINES),
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (inval_i),
    .fill_i     (fill),
    .fill_idx_i (addr_q[OFF_W +: IDX_W]),
    .fill_tag_i (addr_q[ADDR_W-1 -: TAG_W]),
    .fill_line_i(mem_rline_i),
    .upd_i      (upd),
    .upd_idx_i  (addr_q[OFF_W +: IDX_W]),
    .upd_off_i  (addr_q[OFF_W-1:0]),
    .upd_word_i (wdata_q),
    .lk_idx_i   (lk_addr[OFF_W +: IDX_W]),
    .lk_off_i   (lk_addr[OFF_W-1:0]),
    .lk_valid_o (lk_valid),
    .lk_tag_o   (st_tag),
    .lk_word_o  (lk_word)
  );

  assign tag_match = lk_valid && (st_tag == lk_addr[ADDR_W-1 -: TAG_W]);
  assign rd_hit    = accept && !wr_req && active_i && !inval_i && tag_match;
  assign resp      = mem_rvalid_i && (state_q != ST_IDLE);
  // fills only if the buffer was in use at accept and no invalidate touched the fetch
  assign fill      = resp && (state_q == ST_FETCH) && use_q && !kill_q && !inval_i;
  assign upd       = resp && (state_q == ST_WRITE) && tag_match && !inval_i;

  always_comb begin
    resp_word = '0;
    for (int w = 0; w < WORDS; w++)
      if (addr_q[OFF_W-1:0] == OFF_W'(w)) resp_word = mem_rline_i[w*DATA_W +: DATA_W];
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && wr_req)       state_d = ST_WRITE;
        else if (accept && !rd_hit) state_d = ST_FETCH;
      end
      ST_FETCH, ST_WRITE: if (mem_rvalid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      use_q    <= 1'b0;
      kill_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= rd_hit || resp;
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        use_q   <= active_i && !inval_i;
        kill_q  <= 1'b0;
      end else if (inval_i) begin
        kill_q  <= 1'b1;
      end
      if (rd_hit)                              rdata_q <= lk_word;
      else if (resp && (state_q == ST_FETCH))  rdata_q <= resp_word;
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign rvalid_o    = rvalid_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = (state_q == ST_WRITE) ? addr_q
                                             : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = HAS_WR ? wdata_q : '0;
endmodule

// File: rtl/pfb_top.sv
module pfb_top
  import pfb_pkg::*;
#(
  parameter  int unsigned ADDR_W = 16,
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned WORDS  = 4,
  parameter  int unsigned LINES  = 8,
  localparam int unsigned LINE_W = DATA_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_on_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ireq_i,
  input  logic [ADDR_W-1:0] iaddr_i,
  output logic              iready_o,
  output logic              irvalid_o,
  output logic [DATA_W-1:0] irdata_o,
  output logic              imem_req_o,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic              imem_rvalid_i,
  input  logic [LINE_W-1:0] imem_rline_i,
  input  logic              dreq_i,
  input  logic              dwe_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0] dwdata_i,
  output logic              dready_o,
  output logic              drvalid_o,
  output logic [DATA_W-1:0] drdata_o,
  output logic              dmem_req_o,
  output logic              dmem_we_o,
  output logic [ADDR_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  input  logic              dmem_rvalid_i,
  input  logic [LINE_W-1:0] dmem_rline_i
);
  logic              ien, den, inval;
  logic              i_mem_we;
  logic [DATA_W-1:0] i_mem_wdata;

  pfb_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we_i),
    .wdata_i(ctrl_wdata_i),
    .ien_o  (ien),
    .den_o  (den),
    .inval_o(inval)
  );

  pfb_line_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .HAS_WR(1'b0)
  ) u_ibuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (ien && !cache_on_i),
    .inval_i     (inval),
    .req_i       (ireq_i),
    .we_i        (1'b0),
    .addr_i      (iaddr_i),
    .wdata_i     ('0),
    .ready_o     (iready_o),
    .rvalid_o    (irvalid_o),
    .rdata_o     (irdata_o),
    .mem_req_o   (imem_req_o),
    .mem_we_o    (i_mem_we),
    .mem_addr_o  (imem_addr_o),
    .mem_wdata_o (i_mem_wdata),
    .mem_rvalid_i(imem_rvalid_i),
    .mem_rline_i (imem_rline_i)
  );

  pfb_line_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .HAS_WR(1'b1)
  ) u_dbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (den && !cache_on_i),
    .inval_i     (inval),
    .req_i       (dreq_i),
    .we_i        (dwe_i),
    .addr_i      (daddr_i),
    .wdata_i     (dwdata_i),
    .ready_o     (dready_o),
    .rvalid_o    (drvalid_o),
    .rdata_o     (drdata_o),
    .mem_req_o   (dmem_req_o),
    .mem_we_o    (dmem_we_o),
    .mem_addr_o  (dmem_addr_o),
    .mem_wdata_o (dmem_wdata_o),
    .mem_rvalid_i(dmem_rvalid_i),
    .mem_rline_i (dmem_rline_i)
  );
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              iready_o,
  input logic              imem_req_o,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic              i_mem_we,
  input logic [DATA_W-1:0] i_mem_wdata,
  input logic              dreq_i,
  input logic              dready_o,
  input logic              drvalid_o,
  input logic              dmem_req_o,
  input logic              dmem_we_o,
  input logic [ADDR_W-1:0] dmem_addr_o,
  input logic [DATA_W-1:0] dmem_wdata_o,
  input logic              dmem_rvalid_i
);
  assert_line_aligned_d_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_o && !dmem_we_o) |-> (dmem_addr_o[OFF_W-1:0] == '0));

  assert_line_aligned_i_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |-> (imem_addr_o[OFF_W-1:0] == '0));

  assert_busy_not_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_o |-> !dready_o) and (imem_req_o |-> !iready_o));

  // instruction side only ever reads lines
  assert_ifetch_read_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |-> (!i_mem_we && i_mem_wdata == '0));

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_o && !dmem_rvalid_i) |=>
      (dmem_req_o && $stable(dmem_addr_o) && $stable(dmem_we_o) && $stable(dmem_wdata_o)));

  assert_single_response_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_req_o && dmem_rvalid_i) |=> !dmem_req_o);

  assert_rvalid_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drvalid_o |-> ($past(dreq_i && dready_o) || $past(dmem_req_o && dmem_rvalid_i)));
endmodule

bind pfb_top pfb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W($clog2(WORDS))
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .iready_o     (iready_o),
  .imem_req_o   (imem_req_o),
  .imem_addr_o  (imem_addr_o),
  .i_mem_we     (i_mem_we),
  .i_mem_wdata  (i_mem_wdata),
  .dreq_i       (dreq_i),
  .dready_o     (dready_o),
  .drvalid_o    (drvalid_o),
  .dmem_req_o   (dmem_req_o),
  .dmem_we_o    (dmem_we_o),
  .dmem_addr_o  (dmem_addr_o),
  .dmem_wdata_o (dmem_wdata_o),
  .dmem_rvalid_i(dmem_rvalid_i)
);

// File: tb/pfb_top_test.sv
`timescale 1ns/1ps
module pfb_top_test;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         cache_on = 1'b0, ctrl_we = 1'b0;
  logic [2:0]   ctrl_wdata = '0;
  logic         ireq = 1'b0, irdy, irv, imreq, imrv = 1'b0;
  logic [15:0]  iaddr = '0, imaddr;
  logic [31:0]  irdata;
  logic [127:0] imline = '0;
  logic         dreq = 1'b0, dwe = 1'b0, drdy, drv, dmreq, dmwe, dmrv = 1'b0;
  logic [15:0]  daddr = '0, dmaddr;
  logic [31:0]  dwdata = '0, drdata, dmwdata;
  logic [127:0] dmline = '0;

  int checks = 0, errors = 0, mem_lat = 3, icnt = 0, dcnt = 0;
  bit i_wait = 0, d_wait = 0, done = 0;
  logic [31:0] mem [256];
  bit          mv [2][8];
  int          mt [2][8];
  logic [31:0] md [2][8][4];
  bit          m_en [2];
  bit          m_inv = 0;

  always #2 clk = ~clk;

  pfb_top uut (
    .clk_i(clk), .rst_ni(rst_n), .cache_on_i(cache_on),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ireq_i(ireq), .iaddr_i(iaddr), .iready_o(irdy), .irvalid_o(irv), .irdata_o(irdata),
    .imem_req_o(imreq), .imem_addr_o(imaddr), .imem_rvalid_i(imrv), .imem_rline_i(imline),
    .dreq_i(dreq), .dwe_i(dwe), .daddr_i(daddr), .dwdata_i(dwdata),
    .dready_o(drdy), .drvalid_o(drv), .drdata_o(drdata),
    .dmem_req_o(dmreq), .dmem_we_o(dmwe), .dmem_addr_o(dmaddr), .dmem_wdata_o(dmwdata),
    .dmem_rvalid_i(dmrv), .dmem_rline_i(dmline)
  );

  function automatic logic [127:0] build_line(input logic [15:0] a);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = mem[{a[7:2], 2'b00} + w];
    return l;
  endfunction

  // memory responders: one response per held request after mem_lat cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin imrv <= 1'b0; icnt <= 0; end
    else if (imrv) begin imrv <= 1'b0; icnt <= 0; end
    else if (imreq) begin
      if (icnt >= mem_lat - 1) begin imrv <= 1'b1; imline <= build_line(imaddr); end
      else icnt <= icnt + 1;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin dmrv <= 1'b0; dcnt <= 0; end
    else if (dmrv) begin dmrv <= 1'b0; dcnt <= 0; end
    else if (dmreq) begin
      if (dcnt >= mem_lat - 1) begin
        dmrv <= 1'b1;
        dmline <= build_line(dmaddr);
        if (dmwe) mem[dmaddr[7:0]] = dmwdata;
      end else dcnt <= dcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // spurious-response watch on every clock (R2)
  always @(negedge clk) begin
    if (rst_n && irv && !i_wait) chk(1'b0, "R2 unexpected irvalid", 32'(irv), 32'd0);
    if (rst_n && drv && !d_wait) chk(1'b0, "R2 unexpected drvalid", 32'(drv), 32'd0);
  end

  task automatic model_read(input int p, input int a, output logic [31:0] d, output bit h);
    int idx, tg, off;
    bit act;
    idx = (a >> 2) & 7; tg = a >> 5; off = a & 3;
    act = m_en[p] && !cache_on && !m_inv;
    h = act && mv[p][idx] && (mt[p][idx] == tg);
    if (h) d = md[p][idx][off];
    else begin
      d = mem[a];
      if (act) begin
        mv[p][idx] = 1'b1; mt[p][idx] = tg;
        for (int w = 0; w < 4; w++) md[p][idx][w] = mem[(a & ~3) + w];
      end
    end
  endtask

  task automatic do_read(input int p, input int a, input string tag);
    logic [31:0] ed, got;
    bit eh, rdy_low;
    int lat;
    model_read(p, a, ed, eh);
    @(negedge clk);
    if (p == 0) begin ireq = 1'b1; iaddr = 16'(a); i_wait = 1'b1; end
    else begin dreq = 1'b1; dwe = 1'b0; daddr = 16'(a); d_wait = 1'b1; end
    @(negedge clk);
    if (p == 0) ireq = 1'b0; else dreq = 1'b0;
    lat = 1;
    rdy_low = (p == 0) ? !irdy : !drdy;
    while (!((p == 0) ? irv : drv)) begin @(negedge clk); lat++; end
    got = (p == 0) ? irdata : drdata;
    chk(got == ed, {tag, " data"}, got, ed);
    chk((lat == 1) == eh, {tag, " hit/miss latency"}, 32'(lat), eh ? 32'd1 : 32'd2);
    chk(rdy_low == !eh, {tag, " ready during access"}, 32'(!rdy_low), 32'(eh));
    @(posedge clk);
    if (p == 0) i_wait = 1'b0; else d_wait = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [31:0] v);
    int idx, lat;
    bit rdy_low;
    idx = (a >> 2) & 7;
    if (mv[1][idx] && mt[1][idx] == (a >> 5) && !m_inv) md[1][idx][a & 3] = v;
    @(negedge clk);
    dreq = 1'b1; dwe = 1'b1; daddr = 16'(a); dwdata = v; d_wait = 1'b1;
    @(negedge clk);
    dreq = 1'b0; dwe = 1'b0;
    lat = 1; rdy_low = !drdy;
    while (!drv) begin @(negedge clk); lat++; end
    chk(lat > 1 && rdy_low, "R10 write waits for memory", 32'(lat), 32'd2);
    chk(mem[a] == v, "R10 write reached memory", mem[a], v);
    @(posedge clk);
    d_wait = 1'b0;
  endtask

  task automatic ctrl(input bit ie, input bit de, input bit inv);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = {inv, de, ie};
    @(negedge clk);
    ctrl_we = 1'b0;
    m_en[0] = ie; m_en[1] = de; m_inv = inv;
    if (inv) for (int p = 0; p < 2; p++) for (int l = 0; l < 8; l++) mv[p][l] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i * 3);
    m_en[0] = 1; m_en[1] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irdy && drdy, "R1 ready after reset", {30'd0, irdy, drdy}, 32'd3);
    chk(!irv && !drv && !imreq && !dmreq, "R1 idle after reset",
        {28'd0, irv, drv, imreq, dmreq}, 32'd0);

    do_read(1, 'h10, "R1 first read misses R3");
    do_read(1, 'h11, "R2 hit same line");
    do_read(1, 'h13, "R2 hit last word");
    do_read(0, 'h10, "R3 instr miss");
    do_read(0, 'h12, "R2 instr hit");

    do_read(1, 'h30, "R4 conflict miss");
    do_read(1, 'h10, "R4 evicted line misses");
    do_read(1, 'h14, "R4 next index miss");
    do_read(1, 'h11, "R4 resident line hits");

    do_read(1, 'h20, "R3 fill for write test");
    do_write('h21, 32'hA5A5_0001);
    do_read(1, 'h21, "R10 write updated line");
    do_write('h44, 32'h5A5A_0002);
    do_read(1, 'h44, "R10 write does not allocate");

    do_read(1, 'h50, "R3 fill shared line");
    do_read(0, 'h50, "R3 instr fill shared line");
    mem[8'h50] = 32'hFEED_0050;
    do_read(1, 'h50, "R11 stale value returned");
    do_read(0, 'h50, "R11 stale instr value");
    ctrl(1, 1, 1);
    do_read(1, 'h50, "R7 invalidate held miss");
    do_read(1, 'h50, "R7 invalidate held no fill");
    ctrl(1, 1, 0);
    do_read(0, 'h50, "R8 instr cleared by shared invalidate");
    do_read(1, 'h50, "R7 refill after invalidate");
    do_read(1, 'h51, "R7 hit after refill");

    cache_on = 1'b1;
    do_read(1, 'h50, "R5 cache on bypasses");
    do_read(1, 'h60, "R5 cache on no fill");
    cache_on = 1'b0;
    do_read(1, 'h60, "R5 line not filled");
    do_read(1, 'h52, "R5 old line retained");

    ctrl(1, 0, 0);
    do_read(1, 'h52, "R6 data disabled bypass");
    do_read(0, 'h10, "R6 instr fill with data off");
    do_read(0, 'h11, "R6 instr still hits");
    ctrl(0, 1, 0);
    do_read(0, 'h11, "R6 instr disabled bypass");
    do_read(1, 'h53, "R6 data enabled hits");
    ctrl(1, 1, 0);

    mem_lat = 6;
    fork
      do_read(1, 'h70, "R9 read during invalidate pulse");
      begin
        @(negedge clk);
        ctrl(1, 1, 1);
        ctrl(1, 1, 0);
      end
    join
    do_read(1, 'h70, "R9 killed fetch not stored");
    do_read(1, 'h71, "R9 hit after clean refill");
    mem_lat = 3;

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule